// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block decides, for one eight-line interrupt controller, whether a request should be raised toward the processor and which line wins. It takes the request, mask and in-service registers as they stand, together with a rotating priority offset and two mode flags. It reports the winning line as a valid flag plus a line number. The offset moves the top-priority slot around the ring of lines. Priority level p belongs to line (p + offset) mod 8. Level 0 is the most urgent.

A new request is reported only when it is strictly more urgent than the most urgent line already in service. That in-service comparison can be relaxed in two ways. Special masking drops masked lines from it. On the master instance, fully nested operation drops the cascade line from it. The block also reports the most urgent line in the raw in-service register, for use by end-of-interrupt commands. The logic is purely combinational. The register file and the bus side sit around it.

Top module: `prio_resolver`

## Requirements
- R1: Priority level p maps to line (p + rotOffset) mod 8. The pending winner is the line with the smallest level.
- R2: With rotOffset = 0, line 0 is the most urgent and line 7 the least urgent.
- R3: The pending candidates are irqReq AND NOT irqMask. With no candidate, irqValid is 0.
- R4: irqValid is 1 only when the winner's level is strictly below the level of the best line in the comparison in-service set. An equal or lower-urgency request is held back.
- R5: When specialMask = 1, in-service bits that are set in irqMask are left out of the comparison set. When specialMask = 0, all in-service bits take part.
- R6: On an instance with IS_MASTER = 1 and nestedMode = 1, in-service bit 2 (the cascade line) is left out of the comparison set. On an instance with IS_MASTER = 0, nestedMode has no effect on any output.
- R7: svcValid is 1 when inService is nonzero. svcLine is then its most urgent line under the rotation, taken from the unmodified register, so neither specialMask nor nestedMode changes it.
- R8: When irqValid = 1, irqLine equals (winner level + rotOffset) mod 8. When irqValid = 0, irqLine reads 0. When svcValid = 0, svcLine reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irqReq | input | 8 | Request register bits, one per line |
| irqMask | input | 8 | Mask register bits, 1 blocks the line |
| inService | input | 8 | In-service register bits |
| rotOffset | input | 3 | Rotating priority offset: the line at level 0 |
| specialMask | input | 1 | Leave masked lines out of the in-service comparison |
| nestedMode | input | 1 | Fully nested operation; acts only on the master |
| irqValid | output | 1 | An interrupt should be raised |
| irqLine | output | 3 | Winning line number |
| svcValid | output | 1 | Some line is in service |
| svcLine | output | 3 | Most urgent in-service line |

## Verification
Every result is due in the same cycle as its inputs, because no register lies between any input and any output. The bench changes the inputs just after a rising edge and reads all four outputs at the following falling edge, half a period later. It compares them there against a behavioural model that searches the levels one at a time. A master and a slave instance run side by side on the same stimulus. Directed corner cases come first, followed by a long run of random vectors.

// File: rtl/prio_pkg.sv
package prio_pkg;
  // Strobes passed from the mode control to the search datapath.
  typedef struct packed {
    logic hideMasked;   // drop masked lines from the in-service comparison
    logic hideCascade;  // drop the cascade line from the in-service comparison
  } prioStrobes_t;
endpackage

// File: rtl/prio_rank.sv
// Rotated priority search: level of the most urgent set bit, LINES if none.
module prio_rank #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic [LINES-1:0] vec,
  input  logic [LW-1:0]    offset,
  output logic [LW:0]      level
);
  logic [LINES-1:0] rotVec;

  for (genvar p = 0; p < LINES; p++) begin : g_rot
    assign rotVec[p] = vec[LW'(p) + offset];
  end

  always_comb begin
    level = (LW+1)'(LINES);
    for (int p = LINES - 1; p >= 0; p--) begin
      if (rotVec[p]) level = (LW+1)'(p);
    end
  end
endmodule

// File: rtl/prio_control.sv
// Turns the mode flags into comparison strobes for this instance.
module prio_control
  import prio_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic         specialMask,
  input  logic         nestedMode,
  output prioStrobes_t strobes
);
  always_comb begin
    strobes.hideMasked  = specialMask;
    strobes.hideCascade = nestedMode & IS_MASTER;
  end

  // R6: a slave never hides its cascade bit
  always_comb begin
    assert_slave_keeps_cascade_R6: assert (IS_MASTER || !strobes.hideCascade)
      else $error("slave instance hid its cascade line");
  end
endmodule

// File: rtl/prio_datapath.sv
// Candidate and comparison sets, three rotated searches, preemption test.
module prio_datapath
  import prio_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CASCADE_LINE = 2,
  localparam int LW = $clog2(LINES)
) (
  input  logic [LINES-1:0] irqReq,
  input  logic [LINES-1:0] irqMask,
  input  logic [LINES-1:0] inService,
  input  logic [LW-1:0]    rotOffset,
  input  prioStrobes_t     strobes,
  output logic             irqValid,
  output logic [LW-1:0]    irqLine,
  output logic             svcValid,
  output logic [LW-1:0]    svcLine
);
  localparam logic [LINES-1:0] CASCADE_BIT = LINES'(1) << CASCADE_LINE;
  localparam logic [LW:0] NONE_LEVEL = (LW+1)'(LINES);

  logic [LINES-1:0] candVec, cmpVec;
  logic [LW:0] pendLevel, cmpLevel, svcLevel;

  always_comb begin
    candVec = irqReq & ~irqMask;
    cmpVec  = inService;
    if (strobes.hideMasked)  cmpVec = cmpVec & ~irqMask;
    if (strobes.hideCascade) cmpVec = cmpVec & ~CASCADE_BIT;
  end

  prio_rank #(.LINES(LINES)) i_pendRank (.vec(candVec),   .offset(rotOffset), .level(pendLevel));
  prio_rank #(.LINES(LINES)) i_cmpRank  (.vec(cmpVec),    .offset(rotOffset), .level(cmpLevel));
  prio_rank #(.LINES(LINES)) i_svcRank  (.vec(inService), .offset(rotOffset), .level(svcLevel));

  always_comb begin
    irqValid = pendLevel < cmpLevel;
    irqLine  = irqValid ? pendLevel[LW-1:0] + rotOffset : '0;
    svcValid = svcLevel != NONE_LEVEL;
    svcLine  = svcValid ? svcLevel[LW-1:0] + rotOffset : '0;
  end

  always_comb begin
    // R3: a reported line is an unmasked request
    assert_win_pending_R3: assert (!irqValid || (irqReq[irqLine] && !irqMask[irqLine]))
      else $error("winner is not a pending candidate");
    // R4: a reported line is never itself in the comparison set
    assert_strict_R4: assert (!irqValid || !cmpVec[irqLine])
      else $error("winner ties an in-service line");
    // R7: the reported in-service line is really in service
    assert_svc_set_R7: assert (!svcValid || inService[svcLine])
      else $error("service line not in service");
    // R8: idle outputs read zero
    assert_idle_zero_R8: assert ((irqValid || irqLine == '0) && (svcValid || svcLine == '0))
      else $error("idle line output not zero");
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CASCADE_LINE = 2,
  parameter bit IS_MASTER = 1'b1,
  localparam int LW = $clog2(LINES)
) (
  input  logic [LINES-1:0] irqReq,
  input  logic [LINES-1:0] irqMask,
  input  logic [LINES-1:0] inService,
  input  logic [LW-1:0]    rotOffset,
  input  logic             specialMask,
  input  logic             nestedMode,
  output logic             irqValid,
  output logic [LW-1:0]    irqLine,
  output logic             svcValid,
  output logic [LW-1:0]    svcLine
);
  prioStrobes_t strobes;

  prio_control #(.IS_MASTER(IS_MASTER)) i_control (
    .specialMask(specialMask), .nestedMode(nestedMode), .strobes(strobes));

  prio_datapath #(.LINES(LINES), .CASCADE_LINE(CASCADE_LINE)) i_datapath (
    .irqReq(irqReq), .irqMask(irqMask), .inService(inService),
    .rotOffset(rotOffset), .strobes(strobes),
    .irqValid(irqValid), .irqLine(irqLine),
    .svcValid(svcValid), .svcLine(svcLine));
endmodule

// File: tb/test_prio_resolver.sv
module test_prio_resolver;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] irqReq = '0, irqMask = '0, inService = '0;
  logic [2:0] rotOffset = '0;
  logic specialMask = 1'b0, nestedMode = 1'b0;
  logic mValid, sValid, mSvcValid, sSvcValid;
  logic [2:0] mLine, sLine, mSvcLine, sSvcLine;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_resolver #(.IS_MASTER(1'b1)) i_prio_resolver (
    .irqReq(irqReq), .irqMask(irqMask), .inService(inService), .rotOffset(rotOffset),
    .specialMask(specialMask), .nestedMode(nestedMode),
    .irqValid(mValid), .irqLine(mLine), .svcValid(mSvcValid), .svcLine(mSvcLine));

  prio_resolver #(.IS_MASTER(1'b0)) i_slave (
    .irqReq(irqReq), .irqMask(irqMask), .inService(inService), .rotOffset(rotOffset),
    .specialMask(specialMask), .nestedMode(nestedMode),
    .irqValid(sValid), .irqLine(sLine), .svcValid(sSvcValid), .svcLine(sSvcLine));

  // Behavioural level search: smallest p with line (p+off)%8 set, else 8.
  function automatic int refLevel(logic [7:0] v, int off);
    for (int p = 0; p < 8; p++) if (v[(p + off) % 8]) return p;
    return 8;
  endfunction

  task automatic expectEq(int actual, int expected, string tag, string what);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (req=%h mask=%h isr=%h off=%0d sm=%0b nm=%0b)",
               tag, what, actual, expected, irqReq, irqMask, inService, rotOffset, specialMask, nestedMode);
    end
  endtask

  task automatic checkOne(bit master, string tag, logic v, logic [2:0] l, logic sv, logic [2:0] sl);
    int off = int'(rotOffset);
    int pend, cmp, svc, expLine, expSvc;
    logic [7:0] cmpSet;
    bit expValid;
    pend = refLevel(irqReq & ~irqMask, off);
    cmpSet = inService;
    if (specialMask) cmpSet = cmpSet & ~irqMask;
    if (master && nestedMode) cmpSet[2] = 1'b0;
    cmp = refLevel(cmpSet, off);
    svc = refLevel(inService, off);
    expValid = pend < cmp;
    expLine = expValid ? (pend + off) % 8 : 0;
    expSvc = (svc < 8) ? (svc + off) % 8 : 0;
    expectEq(int'(v), int'(expValid), tag, master ? "master irqValid" : "slave irqValid");
    expectEq(int'(l), expLine, tag, master ? "master irqLine" : "slave irqLine");
    expectEq(int'(sv), int'(svc < 8), tag, master ? "master svcValid" : "slave svcValid");
    expectEq(int'(sl), expSvc, tag, master ? "master svcLine" : "slave svcLine");
  endtask

  // Inputs change after a rising edge; outputs are read at the falling edge.
  task automatic apply(logic [7:0] rq, logic [7:0] mk, logic [7:0] is, logic [2:0] off,
                       logic sm, logic nm, string tag);
    @(posedge clk);
    irqReq = rq; irqMask = mk; inService = is; rotOffset = off;
    specialMask = sm; nestedMode = nm;
    @(negedge clk);
    checkOne(1'b1, tag, mValid, mLine, mSvcValid, mSvcLine);
    checkOne(1'b0, tag, sValid, sLine, sSvcValid, sSvcLine);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // idle state
    @(negedge clk);
    expectEq(int'(mValid), 0, "R3", "idle irqValid");
    expectEq(int'(mSvcValid), 0, "R7", "idle svcValid");
    // R2: fixed order at offset 0
    apply(8'hFF, 8'h00, 8'h00, 3'd0, 0, 0, "R2");
    expectEq(int'(mLine), 0, "R2", "all requests pick line 0");
    apply(8'h80, 8'h00, 8'h00, 3'd0, 0, 0, "R2");
    apply(8'h81, 8'h00, 8'h00, 3'd0, 0, 0, "R2");
    // R1: rotation
    apply(8'h05, 8'h00, 8'h00, 3'd3, 0, 0, "R1");
    expectEq(int'(mLine), 0, "R1", "offset 3 picks line 0 over 2");
    apply(8'h14, 8'h00, 8'h00, 3'd3, 0, 0, "R1");
    expectEq(int'(mLine), 4, "R1", "offset 3 picks line 4");
    // R3: masking of candidates
    apply(8'hFF, 8'hFF, 8'h00, 3'd0, 0, 0, "R3");
    expectEq(int'(mValid), 0, "R3", "all masked");
    apply(8'h0C, 8'h04, 8'h00, 3'd0, 0, 0, "R3");
    expectEq(int'(mLine), 3, "R3", "masked line 2 skipped");
    // R4: strict preemption
    apply(8'h08, 8'h00, 8'h08, 3'd0, 0, 0, "R4");
    expectEq(int'(mValid), 0, "R4", "equal level held");
    apply(8'h04, 8'h00, 8'h08, 3'd0, 0, 0, "R4");
    apply(8'h10, 8'h00, 8'h08, 3'd0, 0, 0, "R4");
    // R5: special mask
    apply(8'h10, 8'h02, 8'h02, 3'd0, 1, 0, "R5");
    expectEq(int'(mValid), 1, "R5", "special mask opens lower line");
    apply(8'h10, 8'h02, 8'h02, 3'd0, 0, 0, "R5");
    // R6: cascade line on master vs slave
    apply(8'h04, 8'h00, 8'h04, 3'd0, 0, 1, "R6");
    expectEq(int'(mValid), 1, "R6", "master re-reports cascade");
    expectEq(int'(sValid), 0, "R6", "slave unaffected by nested");
    // R7: service line, unaffected by modes
    apply(8'h00, 8'h00, 8'h22, 3'd2, 0, 0, "R7");
    expectEq(int'(mSvcLine), 5, "R7", "rotated service line");
    apply(8'h00, 8'h02, 8'h06, 3'd0, 1, 1, "R7");
    expectEq(int'(mSvcLine), 1, "R7", "service line ignores modes");
    // R8 and all: random sweep
    for (int i = 0; i < 3000; i++) begin
      apply(8'($urandom), 8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom),
            3'($urandom), 1'($urandom), 1'($urandom), "R8");
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule